// File: doc/BRIEF.md
# Burst Splitting Bus Master Sequencer

This block sits between a local-bus request port and a PCI-style data-phase port. It takes one request at a time and plays it out as a sequence of data phases, each with its own byte address, byte enables and a flag for whether the phase is 64 or 32 bits wide. A request is either a single beat of 1 to 8 bytes within one 8-byte doubleword, or a 32-byte cache-line burst of four doublewords.

A single beat always leaves as 32-bit phases: one phase when its bytes sit in one 32-bit word, two when they straddle the middle of the doubleword. A burst starts with the doubleword named by the request address (the critical word), runs to the end of its line, then wraps to the start of the line and stops just short of the critical word. If the critical word is the first of the line, the wrap part is skipped. Bursts use 64-bit phases when 64-bit mode is on at acceptance. If the target takes only the low half of a 64-bit phase, the remainder of the burst, including any wrap part, goes out as 32-bit phases from the next word. A byte counter and a one-cycle done pulse close each request.

Top module: `burst_split_seq`

## Requirements
- R1: After reset `req_ready` is 1, `ph_valid` is 0, `done` is 0 and `xfer_bytes` is 0.
- R2: A single beat (`req_burst`=0, `req_size` 1..8, bytes not crossing an 8-byte boundary) covers lane mask M = ((1<<size)-1) << addr[2:0], 8 bits. If M[3:0] is nonzero a phase is issued at (addr & ~7) with `ph_be` = {4'b0, M[3:0]}; if M[7:4] is nonzero a phase is then issued at (addr & ~7)+4 with `ph_be` = {4'b0, M[7:4]}. These phases have `ph_wide`=0.
- R3: A burst accepted with `mode64_en`=1 issues phases with `ph_wide`=1, `ph_be`=8'hFF and an 8-aligned address, advancing by 8 per phase.
- R4: A burst accepted with `mode64_en`=0 issues eight 32-bit phases, `ph_be`=8'h0F, advancing by 4.
- R5: A wide phase accepted with `ph_ack64`=0 moves only 4 bytes; all later phases of that burst, in both parts, are 32-bit, starting at that phase's address +4. `ph_ack64` has no effect on 32-bit phases.
- R6: The first part of a burst starts at line base + addr[4:3]*8 (addr[2:0] ignored) and runs to the end of the 32-byte line.
- R7: The second part starts at the line base and ends just before the critical word.
- R8: `ph_first` is 1 on the first phase of each address run (the first phase of a single beat, the first phase of each burst part) and 0 otherwise; a burst with critical offset 0 has one run.
- R9: `done` is 1 for exactly one cycle, the cycle after the last phase is acknowledged; in that cycle `ph_valid` is 0 and `req_ready` is 1.
- R10: `xfer_bytes` is cleared at acceptance and counts bytes moved; at `done` it equals `req_size` for a single beat and 32 for a burst, and holds until the next acceptance.
- R11: While `ph_valid` is 1 and `ph_ack` is 0, the phase outputs stay unchanged in the next cycle.
- R12: `req_ready` is 0 from acceptance until `done`; `req_valid` and the request fields are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted this cycle if valid |
| req_addr | input | ADDR_W | Request byte address |
| req_burst | input | 1 | 1 = cache-line burst, 0 = single beat |
| req_size | input | 4 | Byte count of a single beat (1..8) |
| mode64_en | input | 1 | 64-bit phases allowed for a burst |
| ph_valid | output | 1 | A data phase is offered |
| ph_addr | output | ADDR_W | Byte address of the phase |
| ph_be | output | 8 | Byte enables, bit i = lane i; upper nibble 0 on 32-bit phases |
| ph_wide | output | 1 | Phase is 64 bits wide |
| ph_first | output | 1 | First phase of an address run |
| ph_ack | input | 1 | Target accepts the offered phase |
| ph_ack64 | input | 1 | Target took the full 64 bits of a wide phase |
| done | output | 1 | One-cycle pulse after the final phase |
| xfer_bytes | output | 6 | Bytes moved for the current request |

## Verification
The assertions assume that `ph_ack` and `ph_ack64` are only meaningful while `ph_valid` is high, that single beats never cross a doubleword and have a size from 1 to 8, and that a request is only presented when the previous one is finished or is deliberately held as junk during a busy period. The stimulus sweeps every legal offset and size of a single beat and every critical word, width mode and fallback point of a burst, drops `req_valid` in the cycle of the final acknowledge so no junk request is accepted, inserts one stall cycle on a fixed pattern of phases, and toggles `ph_ack64` on narrow phases to show it is ignored.

// File: rtl/bss_pkg.sv
package bss_pkg;
    localparam int LINE_B = 32;
    localparam int OFF_W  = $clog2(LINE_B);
    localparam int DW_LSB = 3;
    localparam int CNT_W  = OFF_W + 1;

    typedef enum logic [1:0] {
        MD_IDLE   = 2'd0,
        MD_SINGLE = 2'd1,
        MD_BURST  = 2'd2
    } mode_e;
endpackage

// File: rtl/seq_lanes.sv
// Byte-lane mask of a single beat inside one doubleword.
module seq_lanes (
    input  logic [2:0] addr_lo,
    input  logic [3:0] size,
    output logic [7:0] mask
);
    logic [7:0]  fill;
    logic [15:0] shifted;

    always_comb begin
        if (size >= 4'd8) fill = 8'hFF;
        else              fill = (8'h01 << size) - 8'h01;
        shifted = {8'h00, fill} << addr_lo;
        mask    = shifted[7:0];
    end
endmodule

// File: rtl/seq_step.sv
// Offset advance of one burst phase, including width fallback.
module seq_step #(
    parameter int OFF_W = 5
) (
    input  logic [OFF_W-1:0] off,
    input  logic             wide,
    input  logic             ack64,
    output logic [OFF_W:0]   nxt_off,
    output logic [3:0]       step,
    output logic             wide_n
);
    always_comb begin
        wide_n  = wide & ack64;
        step    = wide_n ? 4'd8 : 4'd4;
        nxt_off = {1'b0, off} + {{(OFF_W-3){1'b0}}, step};
    end
endmodule

// File: rtl/burst_split_seq.sv
module burst_split_seq
    import bss_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_burst,
    input  logic [3:0]        req_size,
    input  logic              mode64_en,
    output logic              ph_valid,
    output logic [ADDR_W-1:0] ph_addr,
    output logic [7:0]        ph_be,
    output logic              ph_wide,
    output logic              ph_first,
    input  logic              ph_ack,
    input  logic              ph_ack64,
    output logic              done,
    output logic [5:0]        xfer_bytes
);
    typedef struct packed {
        mode_e             mode;
        logic [ADDR_W-1:0] base;
        logic [OFF_W-1:0]  off;
        logic [OFF_W:0]    stop;
        logic [OFF_W-1:0]  crit;
        logic              part2;
        logic              wide;
        logic              first;
        logic [7:0]        lanes;
        logic [CNT_W-1:0]  bytes;
        logic              done;
    } st_t;

    st_t q, d;

    logic [7:0]     lane_mask;
    logic [OFF_W:0] nxt_off;
    logic [3:0]     step;
    logic           wide_n;
    logic           hi_sel;
    logic [3:0]     cur_nib;
    logic [2:0]     nib_cnt;

    seq_lanes u_lanes (
        .addr_lo (req_addr[DW_LSB-1:0]),
        .size    (req_size),
        .mask    (lane_mask)
    );

    seq_step #(.OFF_W(OFF_W)) u_step (
        .off     (q.off),
        .wide    (q.wide),
        .ack64   (ph_ack64),
        .nxt_off (nxt_off),
        .step    (step),
        .wide_n  (wide_n)
    );

    // current single-beat word: low word first while it still has lanes
    always_comb begin
        hi_sel  = (q.lanes[3:0] == 4'h0);
        cur_nib = hi_sel ? q.lanes[7:4] : q.lanes[3:0];
        nib_cnt = '0;
        for (int i = 0; i < 4; i++) nib_cnt = nib_cnt + {2'b00, cur_nib[i]};
    end

    // phase outputs
    always_comb begin
        req_ready  = (q.mode == MD_IDLE);
        ph_valid   = (q.mode != MD_IDLE);
        ph_first   = q.first & ph_valid;
        done       = q.done;
        xfer_bytes = q.bytes;
        ph_addr    = '0;
        ph_be      = '0;
        ph_wide    = 1'b0;
        case (q.mode)
            MD_SINGLE: begin
                ph_addr = {q.base[ADDR_W-1:DW_LSB], hi_sel, 2'b00};
                ph_be   = {4'h0, cur_nib};
            end
            MD_BURST: begin
                ph_addr = {q.base[ADDR_W-1:OFF_W], q.off};
                ph_be   = q.wide ? 8'hFF : 8'h0F;
                ph_wide = q.wide;
            end
            default: ;
        endcase
    end

    // next state
    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.mode)
            MD_IDLE: begin
                if (req_valid) begin
                    d.bytes = '0;
                    d.first = 1'b1;
                    d.part2 = 1'b0;
                    if (req_burst) begin
                        d.mode                = MD_BURST;
                        d.base                = {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
                        d.crit                = req_addr[OFF_W-1:0];
                        d.crit[DW_LSB-1:0]    = '0;
                        d.off                 = d.crit;
                        d.stop                = CNT_W'(LINE_B);
                        d.wide                = mode64_en;
                        d.lanes               = '0;
                    end else begin
                        d.mode  = MD_SINGLE;
                        d.base  = {req_addr[ADDR_W-1:DW_LSB], {DW_LSB{1'b0}}};
                        d.lanes = lane_mask;
                        d.wide  = 1'b0;
                    end
                end
            end
            MD_SINGLE: begin
                if (ph_ack) begin
                    d.first = 1'b0;
                    d.bytes = q.bytes + {{(CNT_W-3){1'b0}}, nib_cnt};
                    if (hi_sel || q.lanes[7:4] == 4'h0) begin
                        d.mode  = MD_IDLE;
                        d.lanes = '0;
                        d.done  = 1'b1;
                    end else begin
                        d.lanes[3:0] = 4'h0;
                    end
                end
            end
            MD_BURST: begin
                if (ph_ack) begin
                    d.first = 1'b0;
                    d.wide  = wide_n;
                    d.bytes = q.bytes + {{(CNT_W-4){1'b0}}, step};
                    if (nxt_off == q.stop) begin
                        if (!q.part2 && q.crit != '0) begin
                            d.part2 = 1'b1;
                            d.off   = '0;
                            d.stop  = {1'b0, q.crit};
                            d.first = 1'b1;
                        end else begin
                            d.mode = MD_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.off = nxt_off[OFF_W-1:0];
                    end
                end
            end
            default: d.mode = MD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.mode <= MD_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/burst_split_seq_chk.sv
module burst_split_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              ph_valid,
    input logic [ADDR_W-1:0] ph_addr,
    input logic [7:0]        ph_be,
    input logic              ph_wide,
    input logic              ph_first,
    input logic              ph_ack,
    input logic              ph_ack64,
    input logic              done,
    input logic [5:0]        xfer_bytes
);
    // R11
    hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_valid && !ph_ack |=> ph_valid && $stable(ph_addr) && $stable(ph_be)
                                && $stable(ph_wide) && $stable(ph_first));

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ph_valid && req_ready && xfer_bytes != 6'd0);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_valid |-> !req_ready);

    // R12
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> ph_valid && ph_first);

    // R3
    wide_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_valid && ph_wide |-> ph_be == 8'hFF && ph_addr[2:0] == 3'b000);

    // R2
    narrow_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_valid && !ph_wide |-> ph_be[7:4] == 4'h0 && ph_be[3:0] != 4'h0
                                  && ph_addr[1:0] == 2'b00);

    // R5
    fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_valid && ph_wide && ph_ack && !ph_ack64 |=> ph_valid && !ph_wide);

    // R5
    no_regain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_valid && !ph_wide |=> !ph_valid || !ph_wide || ph_first);
endmodule

bind burst_split_seq burst_split_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .ph_valid   (ph_valid),
    .ph_addr    (ph_addr),
    .ph_be      (ph_be),
    .ph_wide    (ph_wide),
    .ph_first   (ph_first),
    .ph_ack     (ph_ack),
    .ph_ack64   (ph_ack64),
    .done       (done),
    .xfer_bytes (xfer_bytes)
);

// File: tb/tb_burst_split_seq.sv
module tb_burst_split_seq;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic          req_burst = 1'b0;
    logic [3:0]    req_size = 4'd0;
    logic          mode64_en = 1'b0;
    logic          ph_valid;
    logic [AW-1:0] ph_addr;
    logic [7:0]    ph_be;
    logic          ph_wide;
    logic          ph_first;
    logic          ph_ack = 1'b0;
    logic          ph_ack64 = 1'b0;
    logic          done;
    logic [5:0]    xfer_bytes;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    burst_split_seq #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_burst(req_burst), .req_size(req_size),
        .mode64_en(mode64_en), .ph_valid(ph_valid), .ph_addr(ph_addr),
        .ph_be(ph_be), .ph_wide(ph_wide), .ph_first(ph_first), .ph_ack(ph_ack),
        .ph_ack64(ph_ack64), .done(done), .xfer_bytes(xfer_bytes)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // phase tuple: {valid, wide, first, be, addr}
    function automatic logic [63:0] tup(input logic v, input logic w, input logic f,
                                        input logic [7:0] be, input logic [31:0] a);
        return {21'd0, v, w, f, be, a};
    endfunction

    task automatic start_req(input logic [31:0] a, input logic b, input logic [3:0] sz,
                             input logic m64, input bit junk);
        req_valid = 1'b1; req_addr = a; req_burst = b; req_size = sz; mode64_en = m64;
        @(posedge clk); @(negedge clk);
        req_valid = junk;
        req_addr  = ~a;
        req_burst = ~b;
        req_size  = 4'd3;
        mode64_en = ~m64;
    endtask

    // checks one expected phase, with an optional stall cycle first
    task automatic one_phase(input string tag, input logic w, input logic f,
                             input logic [7:0] be, input logic [31:0] a,
                             input bit stall, input logic a64, input bit last);
        chk({tag, " phase"}, tup(ph_valid, ph_wide, ph_first, ph_be, ph_addr),
            tup(1'b1, w, f, be, a));
        chk("R12 busy not ready", {63'd0, req_ready}, 64'd0);
        if (stall) begin
            ph_ack = 1'b0; ph_ack64 = ~a64;
            @(posedge clk); @(negedge clk);
            chk("R11 held phase", tup(ph_valid, ph_wide, ph_first, ph_be, ph_addr),
                tup(1'b1, w, f, be, a));
        end
        ph_ack = 1'b1; ph_ack64 = a64;
        if (last) req_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        ph_ack = 1'b0; ph_ack64 = 1'b0;
    endtask

    task automatic finish_req(input string tag, input int nbytes);
        chk({tag, " R9 done pulse/idle"}, {61'd0, done, ph_valid, req_ready}, {61'd0, 3'b101});
        chk({tag, " R10 byte count"}, {58'd0, xfer_bytes}, nbytes);
        @(posedge clk); @(negedge clk);
        chk({tag, " R9 done one cycle"}, {63'd0, done}, 64'd0);
        chk({tag, " R10 count holds"}, {58'd0, xfer_bytes}, nbytes);
    endtask

    task automatic run_single(input int lo, input int sz, input bit junk);
        logic [31:0] a, dw;
        logic [7:0]  m;
        a  = 32'h8000_1238 + lo;
        dw = 32'h8000_1238;
        m  = 8'((9'h1FF >> (9 - sz)) << lo);
        start_req(a, 1'b0, 4'(sz), 1'b1, junk);
        if (m[3:0] != 4'h0)
            one_phase("R2 single low", 1'b0, 1'b1, {4'h0, m[3:0]}, dw,
                      (lo % 3) == 0, lo[0], m[7:4] == 4'h0);
        if (m[7:4] != 4'h0)
            one_phase("R2 single high", 1'b0, m[3:0] == 4'h0, {4'h0, m[7:4]}, dw + 4,
                      (sz % 3) == 1, sz[0], 1'b1);
        finish_req("R2 single", sz);
    endtask

    task automatic run_burst(input int crit, input bit m64, input int decl, input bit junk);
        logic [31:0] base;
        int pos, k, stopv;
        bit part, wide, first, last, a64;
        string tg;
        base  = 32'h4000_0A00;
        pos   = crit * 8;
        stopv = 32;
        part  = 0; wide = m64; first = 1; k = 0; last = 0;
        start_req(base + pos + (crit % 8), 1'b1, 4'd0, m64, junk);
        while (!last && k < 20) begin
            a64 = wide ? (k != decl) : k[0];
            if (part) tg = "R7 wrap";
            else if (!wide && m64) tg = "R5 fallback";
            else if (m64) tg = "R3/R6 wide";
            else tg = "R4/R6 narrow";
            // last-phase determination from the expected walk
            begin
                int np;
                np = pos + ((wide && a64) ? 8 : 4);
                if (np == stopv) begin
                    if (!part && crit != 0) begin
                        one_phase(tg, wide, first, wide ? 8'hFF : 8'h0F, base + pos,
                                  (k % 3) == 1, a64, 1'b0);
                        part = 1; pos = 0; stopv = crit * 8; first = 1;
                        wide = wide && a64;
                        k++;
                        continue;
                    end
                    last = 1;
                end
                one_phase(tg, wide, first, wide ? 8'hFF : 8'h0F, base + pos,
                          (k % 3) == 1, a64, last);
                pos = np; first = 0; wide = wide && a64; k++;
            end
        end
        if (crit == 0) chk("R8 single run count", k, (m64 && decl < 0) ? 4 : ((m64) ? 5 + (3 - decl) : 8));
        finish_req("R10 burst", 32);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", {58'd0, req_ready, ph_valid, done, 1'b0, 2'b00},
            {58'd0, 1'b1, 1'b0, 1'b0, 3'b000});
        chk("R1 reset count", {58'd0, xfer_bytes}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {61'd0, req_ready, ph_valid, done}, {61'd0, 3'b100});

        for (int lo = 0; lo < 8; lo++)
            for (int sz = 1; sz <= 8 - lo; sz++)
                run_single(lo, sz, ((lo + sz) % 2) == 1);

        for (int c = 0; c < 4; c++)
            for (int m = 0; m < 2; m++)
                for (int dcl = -1; dcl < 4; dcl++)
                    if (m == 1 || dcl < 0)
                        run_burst(c, m[0], dcl, ((c + dcl) % 2) == 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule